// File: doc/BRIEF.md
# Drive LED Serial Shifter

This block holds the activity, locate and fault indicator bits for up to eight drive ports. It sends the whole indicator image to an external LED controller over a three-wire serial link made of a clock, a load and a data line. Each accepted update strobe carries a port number and a 32-bit state word. The block decodes the three indicator flags from fixed bits of that word and writes them into the image at a position chosen by a per-port slot remapping table. It then sends a complete frame.

A frame opens with one slow clock cycle with load held high. It continues with one clock cycle per image bit, least significant bit first, for three bits per configured port. Each clock half lasts a parameterised number of system cycles, 2500 by default, which is 50 µs at 50 MHz. While a frame is in flight the block reports busy and drops further strobes, so each update and its frame form one indivisible operation.

Top module: `sgpio_led_shifter`

## Requirements
- R1: After reset the clock, load and data lines are all high, busy is low and every image bit is clear.
- R2: A port's three indicator bits sit at image index 3*slot + offset, where slot is `slot_map_i[3*port +: 3]` and the offset is 0 for fault, 1 for locate and 2 for activity.
- R3: Activity is set when state bit 20 or bit 21 is set, locate follows state bit 19 and fault follows state bit 22. An accepted update writes all three bits of its slot, set or clear, and leaves every other slot's bits unchanged.
- R4: A strobe whose state bits [15:8] are not below MSG_SLOTS (default 15) is rejected: busy stays low, no frame is sent and the image is unchanged.
- R5: Each frame starts with load high for one full clock cycle (a high half, then a low half) and sends exactly one load-qualified rising clock edge.
- R6: After the load cycle, exactly 3*n_ports_i data bits follow, least significant image bit first. Bit k is the value of data on the (k+1)-th rising clock edge that comes with load low.
- R7: Every clock high half within a frame lasts HALF_CYC system cycles. A frame lasts 1 + 2*HALF_CYC + 3*n_ports_i*(1 + 2*HALF_CYC) cycles.
- R8: The data and load lines change only in cycles where the clock line is low.
- R9: Busy rises on the cycle after an accepted strobe and stays high until the last low half ends. Strobes that arrive while busy is high are ignored.
- R10: At the end of a frame the clock and load lines rest low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | Update strobe |
| upd_port_i | input | 3 | Port being updated |
| upd_state_i | input | 32 | Indicator state word |
| n_ports_i | input | 4 | Number of ports in a frame, 1 to MAX_PORTS |
| slot_map_i | input | 24 | Slot number per port, 3 bits each, port 0 in the lowest bits |
| sclk_o | output | 1 | Serial clock |
| sload_o | output | 1 | Serial load |
| sdata_o | output | 1 | Serial data |
| busy_o | output | 1 | Frame in progress |

## Verification
The following are checked by assertions on every cycle:
- data and load change only while the clock is low;
- every clock high half within a frame has the right length;
- busy and load follow an accepted strobe, and busy stays low after a rejected one;
- the lines rest low when busy falls.

Other behaviour can only be shown by the bench scenarios. A model of the external shift register captures each frame. The bench then compares the frame with an image it tracks itself, across remapped and colliding slots and several port counts. The bench also covers strobes dropped while busy, and it checks that a rejected strobe leaves the image unchanged by examining the next frame.

// File: rtl/sgpio_led_pkg.sv
package sgpio_led_pkg;
  localparam int SIG_PER_SLOT = 3;
  localparam int FLT_OFS      = 0;
  localparam int LOC_OFS      = 1;
  localparam int ACT_OFS      = 2;

  localparam logic [31:0] ACT_MASK = 32'h0030_0000;
  localparam logic [31:0] LOC_MASK = 32'h0008_0000;
  localparam logic [31:0] FLT_MASK = 32'h0040_0000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LSETUP, ST_LHI, ST_LLO, ST_DSETUP, ST_DHI, ST_DLO
  } xfer_state_e;

  typedef struct packed {
    logic act;
    logic loc;
    logic flt;
  } led_req_t;

  function automatic led_req_t decode_state(logic [31:0] s);
    led_req_t r;
    r.act = |(s & ACT_MASK);
    r.loc = |(s & LOC_MASK);
    r.flt = |(s & FLT_MASK);
    return r;
  endfunction
endpackage

// File: rtl/sgpio_led_pattern.sv
module sgpio_led_pattern
  import sgpio_led_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int PORT_W    = 3,
  parameter int SLOT_W    = 3,
  parameter int PAT_W     = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        write_i,
  input  logic [PORT_W-1:0]           port_i,
  input  led_req_t                    req_i,
  input  logic [MAX_PORTS*SLOT_W-1:0] slot_map_i,
  output logic [PAT_W-1:0]            pattern_o
);
  logic [SLOT_W-1:0] slot;

  always_comb begin
    slot = '0;
    for (int i = 0; i < MAX_PORTS; i++)
      if (port_i == PORT_W'(i)) slot = slot_map_i[i*SLOT_W +: SLOT_W];
  end

  for (genvar g = 0; g < MAX_PORTS; g++) begin : g_slot
    logic [SIG_PER_SLOT-1:0] bits_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bits_q <= '0;
      else if (write_i && slot == SLOT_W'(g)) begin
        bits_q[FLT_OFS] <= req_i.flt;
        bits_q[LOC_OFS] <= req_i.loc;
        bits_q[ACT_OFS] <= req_i.act;
      end
    end
    assign pattern_o[g*SIG_PER_SLOT +: SIG_PER_SLOT] = bits_q;
  end
endmodule

// File: rtl/sgpio_half_timer.sv
module sgpio_half_timer #(
  parameter int HALF_CYC = 2500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic done_o
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || done_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sgpio_frame_fsm.sv
module sgpio_frame_fsm
  import sgpio_led_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int PAT_W     = 24,
  parameter int NP_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [PAT_W-1:0] pattern_i,
  input  logic [NP_W-1:0]  n_ports_i,
  input  logic             tick_i,
  output logic             timer_clr_o,
  output logic             sclk_o,
  output logic             sload_o,
  output logic             sdata_o,
  output logic             busy_o
);
  localparam int BIT_W = $clog2(PAT_W + 1);

  xfer_state_e      state_q;
  logic [PAT_W-1:0] shreg_q;
  logic [BIT_W-1:0] left_q;
  logic [BIT_W-1:0] frame_bits;
  logic             sclk_q, sload_q, sdata_q;

  assign frame_bits  = BIT_W'(SIG_PER_SLOT * int'(n_ports_i));
  assign timer_clr_o = (state_q == ST_IDLE) || (state_q == ST_LSETUP) || (state_q == ST_DSETUP);
  assign busy_o      = (state_q != ST_IDLE);
  assign sclk_o      = sclk_q;
  assign sload_o     = sload_q;
  assign sdata_o     = sdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sclk_q  <= 1'b1;
      sload_q <= 1'b1;
      sdata_q <= 1'b1;
      shreg_q <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LSETUP;
          sload_q <= 1'b1;
          sclk_q  <= 1'b0;
        end
        ST_LSETUP: begin
          state_q <= ST_LHI;
          sclk_q  <= 1'b1;
        end
        ST_LHI: if (tick_i) begin
          state_q <= ST_LLO;
          sclk_q  <= 1'b0;
          shreg_q <= pattern_i;
          left_q  <= frame_bits;
        end
        ST_LLO, ST_DLO: if (tick_i) begin
          if (state_q == ST_DLO && left_q == '0) begin
            state_q <= ST_IDLE;
          end else begin
            // next bit is set up while the clock is low
            state_q <= ST_DSETUP;
            sload_q <= 1'b0;
            sdata_q <= shreg_q[0];
            shreg_q <= shreg_q >> 1;
            left_q  <= left_q - 1'b1;
          end
        end
        ST_DSETUP: begin
          state_q <= ST_DHI;
          sclk_q  <= 1'b1;
        end
        ST_DHI: if (tick_i) begin
          state_q <= ST_DLO;
          sclk_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgpio_led_shifter.sv
module sgpio_led_shifter
  import sgpio_led_pkg::*;
#(
  parameter int MAX_PORTS = 8,
  parameter int HALF_CYC  = 2500,
  parameter int MSG_SLOTS = 15
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                upd_valid_i,
  input  logic [$clog2(MAX_PORTS)-1:0]        upd_port_i,
  input  logic [31:0]                         upd_state_i,
  input  logic [$clog2(MAX_PORTS+1)-1:0]      n_ports_i,
  input  logic [MAX_PORTS*$clog2(MAX_PORTS)-1:0] slot_map_i,
  output logic                                sclk_o,
  output logic                                sload_o,
  output logic                                sdata_o,
  output logic                                busy_o
);
  localparam int PORT_W = $clog2(MAX_PORTS);
  localparam int NP_W   = $clog2(MAX_PORTS + 1);
  localparam int PAT_W  = SIG_PER_SLOT * MAX_PORTS;

  logic             accept, tick, timer_clr;
  logic [PAT_W-1:0] pattern;

  assign accept = upd_valid_i && !busy_o && (int'(upd_state_i[15:8]) < MSG_SLOTS);

  sgpio_led_pattern #(
    .MAX_PORTS(MAX_PORTS), .PORT_W(PORT_W), .SLOT_W(PORT_W), .PAT_W(PAT_W)
  ) u_pattern (
    .clk_i, .rst_ni,
    .write_i   (accept),
    .port_i    (upd_port_i),
    .req_i     (decode_state(upd_state_i)),
    .slot_map_i,
    .pattern_o (pattern)
  );

  sgpio_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i, .rst_ni,
    .clr_i  (timer_clr),
    .done_o (tick)
  );

  sgpio_frame_fsm #(
    .MAX_PORTS(MAX_PORTS), .PAT_W(PAT_W), .NP_W(NP_W)
  ) u_fsm (
    .clk_i, .rst_ni,
    .start_i     (accept),
    .pattern_i   (pattern),
    .n_ports_i,
    .tick_i      (tick),
    .timer_clr_o (timer_clr),
    .sclk_o, .sload_o, .sdata_o, .busy_o
  );
endmodule

// File: rtl/sgpio_led_shifter_chk.sv
module sgpio_led_shifter_chk #(
  parameter int MAX_PORTS = 8,
  parameter int HALF_CYC  = 2500,
  parameter int MSG_SLOTS = 15
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        upd_valid_i,
  input logic [31:0] upd_state_i,
  input logic        sclk_o,
  input logic        sload_o,
  input logic        sdata_o,
  input logic        busy_o
);
  logic [31:0] hi_cnt;
  logic        slot_ok;

  assign slot_ok = int'(upd_state_i[15:8]) < MSG_SLOTS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_cnt <= '0;
    else if (sclk_o && busy_o) hi_cnt <= hi_cnt + 1;
    else hi_cnt <= '0;
  end

  p_data_clk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !sclk_o);
  p_load_clk_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sload_o) |-> !sclk_o);
  p_load_in_frame_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sload_o) |-> busy_o);
  p_accept_starts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !busy_o && slot_ok |=> busy_o && sload_o && !sclk_o);
  p_reject_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !busy_o && !slot_ok |=> !busy_o);
  p_high_half_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) && $past(busy_o) |-> hi_cnt == 32'(HALF_CYC));
  p_rest_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !sclk_o && !sload_o);
endmodule

bind sgpio_led_shifter sgpio_led_shifter_chk #(
  .MAX_PORTS(MAX_PORTS), .HALF_CYC(HALF_CYC), .MSG_SLOTS(MSG_SLOTS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .upd_valid_i(upd_valid_i), .upd_state_i(upd_state_i),
  .sclk_o(sclk_o), .sload_o(sload_o), .sdata_o(sdata_o), .busy_o(busy_o)
);

// File: tb/sgpio_led_shifter_bench.sv
module sgpio_led_shifter_bench;
  localparam int MP = 8;
  localparam int H  = 3;
  localparam int MS = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  port = '0;
  logic [31:0] state = '0;
  logic [3:0]  nports = 4'd8;
  logic [23:0] smap = '0;
  logic        sclk, sload, sdata, busy;

  int n_checks = 0, n_errors = 0;
  logic [23:0] exp_pat = '0;
  logic [31:0] rx_vec = '0;
  int rx_cnt = 0, loads = 0, hi_run = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sgpio_led_shifter #(.MAX_PORTS(MP), .HALF_CYC(H), .MSG_SLOTS(MS)) u_sgpio_led_shifter (
    .clk_i(clk), .rst_ni(rst_n), .upd_valid_i(valid), .upd_port_i(port),
    .upd_state_i(state), .n_ports_i(nports), .slot_map_i(smap),
    .sclk_o(sclk), .sload_o(sload), .sdata_o(sdata), .busy_o(busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // external LED controller model
  always @(posedge sclk) if (rst_n) begin
    if (sload) begin
      rx_cnt = 0;
      loads++;
    end else begin
      if (rx_cnt < 32) rx_vec[rx_cnt] = sdata;
      rx_cnt++;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (sclk && busy) hi_run++;
    else if (hi_run > 0) begin
      check(hi_run == H, "R7 high half", hi_run, H);
      hi_run = 0;
    end
  end

  function automatic logic [23:0] apply(input logic [23:0] p, input int slot, input logic [31:0] st);
    logic [23:0] r = p;
    r[3*slot+2] = st[21] | st[20];
    r[3*slot+1] = st[19];
    r[3*slot]   = st[22];
    return r;
  endfunction

  task automatic update(input int p, input logic [31:0] st, input bit intrude);
    int l0, cyc, n, mism;
    bit acc;
    while (busy) @(negedge clk);
    @(negedge clk);
    n = int'(nports);
    l0 = loads;
    acc = (int'(st[15:8]) < MS);
    valid = 1'b1; port = 3'(p); state = st;
    @(negedge clk);
    valid = 1'b0;
    if (!acc) begin
      check(busy == 1'b0, "R4 reject no busy", 32'(busy), 0);
      repeat (2*H + 4) @(negedge clk);
      check(loads == l0, "R4 reject no frame", loads, l0);
      check(busy == 1'b0, "R4 still idle", 32'(busy), 0);
      return;
    end
    exp_pat = apply(exp_pat, int'(smap[3*p +: 3]), st);
    check(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    cyc = 0;
    while (busy && cyc < 2000) begin
      cyc++;
      if (intrude && cyc == 10) begin
        valid = 1'b1; port = 3'((p + 1) % MP); state = 32'h0078_0000;
      end else valid = 1'b0;
      @(negedge clk);
    end
    valid = 1'b0;
    check(cyc == 1 + 2*H + 3*n*(1 + 2*H), "R7 frame length", cyc, 1 + 2*H + 3*n*(1 + 2*H));
    check(loads == l0 + 1, "R5 one load cycle", loads, l0 + 1);
    check(rx_cnt == 3*n, "R6 bit count", rx_cnt, 3*n);
    mism = 0;
    for (int k = 0; k < 3*n; k++) if (rx_vec[k] !== exp_pat[k]) mism++;
    check(mism == 0, "R2/R3 image bits", rx_vec & ((32'd1 << (3*n)) - 1), {8'd0, exp_pat} & ((32'd1 << (3*n)) - 1));
    check(!sclk && !sload, "R10 rest low", {30'd0, sclk, sload}, 0);
    if (intrude) begin
      repeat (2*H + 4) @(negedge clk);
      check(busy == 1'b0 && loads == l0 + 1, "R9 strobe while busy ignored", loads, l0 + 1);
    end
  endtask

  initial begin
    logic [31:0] st;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < MP; i++) smap[3*i +: 3] = 3'(i);
    repeat (3) @(negedge clk);
    check(sclk && sload && sdata && !busy, "R1 reset lines", {28'd0, sclk, sload, sdata, busy}, 32'he);
    rst_n = 1'b1;
    @(negedge clk);
    check(sclk && sload && sdata && !busy, "R1 idle after reset", {28'd0, sclk, sload, sdata, busy}, 32'he);
    // directed: each flag alone, then a clear
    update(0, 32'h0010_0000, 0);  // R3 activity via bit 20
    update(7, 32'h0040_0000, 0);  // R3 fault
    update(3, 32'h0028_0000, 0);  // R3 activity bit 21 + locate
    update(0, 32'h0000_0000, 0);  // R3 clear
    update(5, 32'h0040_0F00, 0);  // R4 slot field 15 rejected
    update(5, 32'h0040_0E00, 0);  // slot field 14 accepted
    update(2, 32'h0010_0000, 1);  // R9 intrude on port 3
    // R2 remap: reversed slots, five ports
    for (int i = 0; i < MP; i++) smap[3*i +: 3] = 3'(MP - 1 - i);
    nports = 4'd5;
    for (int i = 0; i < 14; i++) begin
      st = $urandom & 32'h0078_0F00;
      update(int'($urandom % MP), st, 0);
    end
    // colliding slots, small frames
    for (int i = 0; i < MP; i++) smap[3*i +: 3] = 3'(i % 3);
    nports = 4'd1;
    for (int i = 0; i < 6; i++) update(int'($urandom % MP), $urandom & 32'h0078_0700, 0);
    nports = 4'd3;
    for (int i = 0; i < 6; i++) update(int'($urandom % MP), $urandom & 32'h0078_0F00, 0);
    nports = 4'd8;
    for (int i = 0; i < MP; i++) smap[3*i +: 3] = 3'(i);
    for (int i = 0; i < 8; i++) update(i, $urandom & 32'h0078_0000, i == 4);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule